// File: doc/BRIEF.md
# Over-Current Shutdown Sequencer for a Half-Bridge Driver

This block decides, every clock cycle, whether a half-bridge gate driver may switch or must hold both gates off. It watches over-current flags from the high-side and low-side sense paths, but only while the matching side is being driven and only after that side has been on for a blanking time. When a fault is accepted it latches and forces shutdown. A single up/down timing counter replaces an external timing capacitor. In the default self-restart mode the counter drains to a low mark, which clears the fault latch. It then refills to a high mark, and at that point the driver is released. The same refill provides the start-up delay after reset and after a supply dropout.

In latched mode an accepted fault holds the driver off until a host pulls the request input for a minimum number of cycles. The same pulse is needed after start-up before the driver runs at all. The request input is asynchronous and passes through a two-flop synchroniser. In either mode, while it is asserted it forces shutdown and empties the counter. A status output lets a host see that the fault latch is set or that the driver is being held off.

Top module: `ocp_shutdown_seq`

## Requirements
- R1: While reset is asserted, `halt` and `fault` are both 1.
- R2: The counter is 0 after reset, rises by STEP_UP per cycle while charging and saturates at FULL. The low mark is LO = FULL*3/10 and the high mark is HI = FULL*7/10. In self-restart mode, with supplies good and no request, `halt` falls on the clock edge at which the counter, before that edge, is at least HI. With STEP_UP=1 this is HI+1 cycles after reset is released.
- R3: An over-current is accepted when `halt` is 0, the side's drive input is 1, its blanking has expired and its flag is 1 at a clock edge. After that edge `halt` and `fault` are 1.
- R4: A side's flag has no effect while that side's drive input is 0, or during the first BLANK clock edges at which its drive input is 1. The first such edge counts as edge 0, so a flag is first accepted at edge BLANK.
- R5: In self-restart mode an accepted fault holds the count while it sets the latch. The counter then falls by STEP_DN per edge, and on the first edge that finds it below LO the latch clears. It then charges as in R2. With unit steps and a count C at the fault, `halt` is 1 for C + HI - 2*LO + 4 cycles.
- R6: If the over-current persists after release, the sequence repeats. `halt` is 0 for exactly one cycle, and the next shutdown starts from the count HI+STEP_UP.
- R7: If `sup_a_ok` or `sup_b_ok` is 0, `halt` is 1 in the same cycle. At the next edge the counter is cleared, the fault latch is cleared and shutdown is entered. After both supplies are good again, release follows the R2 timing.
- R8: In latched mode an accepted fault keeps `halt` and `fault` at 1 for as long as no qualifying request arrives.
- R9: In latched mode the driver is released only after a qualifying request. A request qualifies when it has been seen for at least RST_MIN consecutive synchronised cycles. This is also required after reset and after a supply dropout. A shorter request leaves the block in shutdown. Once a qualifying request ends, release follows the R2 timing.
- R10: While the synchronised request is 1, in either mode, the block is in shutdown and the counter and fault latch are cleared. With unit steps, `halt` falls HI+3 cycles after the request input is removed.
- R11: `fault` is 1 exactly when the fault latch is set or the block is in shutdown. It is 0 whenever the driver is released.
- R12: `ext_req` passes through two flops. A request driven before edge n first affects `halt` after edge n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| oc_hi | input | 1 | High-side over-current comparator flag |
| oc_lo | input | 1 | Low-side over-current comparator flag |
| drv_hi | input | 1 | High-side drive command (1 = on) |
| drv_lo | input | 1 | Low-side drive command (1 = on) |
| sup_a_ok | input | 1 | First supply above its lockout level |
| sup_b_ok | input | 1 | Second supply above its lockout level |
| latch_mode | input | 1 | 1 = latched protection, 0 = self-restart |
| ext_req | input | 1 | Asynchronous host reset/shutdown request |
| halt | output | 1 | 1 = both gate outputs forced off |
| fault | output | 1 | Fault latch set or block in shutdown |

## Verification
The release of shutdown and the acceptance of a new over-current can fall on adjacent edges with no idle gap between them. This happens when the high-side drive stays on and its flag stays high through a whole self-restart sequence. The blanking has already expired, so the flag is seen on the very first edge of normal operation. The bench requires `halt` to be low for exactly one cycle. It then requires the second shutdown to last the duration computed from a starting count of HI+1 rather than FULL, which shows that the discharge begins from the count held at release and not from a recharged full scale.

// File: rtl/ocp_shutdown_seq.sv
`timescale 1ns/1ps
module ocp_shutdown_seq #(
  parameter int FULL    = 1000,
  parameter int STEP_UP = 1,
  parameter int STEP_DN = 1,
  parameter int BLANK   = 45,
  parameter int RST_MIN = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_hi,
  input  logic oc_lo,
  input  logic drv_hi,
  input  logic drv_lo,
  input  logic sup_a_ok,
  input  logic sup_b_ok,
  input  logic latch_mode,
  input  logic ext_req,
  output logic halt,
  output logic fault
);
  localparam int LO = FULL * 3 / 10;
  localparam int HI = FULL * 7 / 10;
  localparam int CW = $clog2(FULL + 1);
  localparam int BW = $clog2(BLANK + 1);
  localparam int RW = $clog2(RST_MIN + 1);

  logic [1:0]    req_ff;
  logic          req_s;
  logic [RW-1:0] rq;
  logic          qualify;
  logic [1:0]    drv_v, oc_v, armed;
  logic          oc_hit, sup_ok, rel, rel_eff, flt, shut;
  logic [CW-1:0] cnt, cnt_up, cnt_dn;
  logic [CW:0]   up_sum;

  assign drv_v   = {drv_hi, drv_lo};
  assign oc_v    = {oc_hi, oc_lo};
  assign req_s   = req_ff[1];
  assign sup_ok  = sup_a_ok & sup_b_ok;
  assign oc_hit  = |(drv_v & oc_v & armed);
  assign rel_eff = rel | ~latch_mode;
  assign qualify = req_s && (rq == RW'(RST_MIN - 1));

  genvar s;
  for (s = 0; s < 2; s++) begin : g_side
    logic [BW-1:0] bc;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 bc <= '0;
      else if (!drv_v[s])         bc <= '0;
      else if (bc != BW'(BLANK))  bc <= bc + 1'b1;
    end
    assign armed[s] = drv_v[s] && (bc == BW'(BLANK));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_ff <= '0;
      rq     <= '0;
    end else begin
      req_ff <= {req_ff[0], ext_req};
      if (!req_s)                   rq <= '0;
      else if (rq != RW'(RST_MIN))  rq <= rq + 1'b1;
    end
  end

  assign up_sum = {1'b0, cnt} + (CW+1)'(STEP_UP);
  assign cnt_up = (up_sum > (CW+1)'(FULL)) ? CW'(FULL) : up_sum[CW-1:0];
  assign cnt_dn = (cnt >= CW'(STEP_DN)) ? cnt - CW'(STEP_DN) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      flt  <= 1'b0;
      shut <= 1'b1;
      rel  <= 1'b0;
    end else if (!sup_ok) begin
      cnt  <= '0;
      flt  <= 1'b0;
      shut <= 1'b1;
      rel  <= 1'b0;
    end else if (req_s) begin
      cnt  <= '0;
      flt  <= 1'b0;
      shut <= 1'b1;
      if (qualify) rel <= 1'b1;
    end else if (oc_hit && !shut) begin
      flt  <= 1'b1;
      shut <= 1'b1;
      if (latch_mode) rel <= 1'b0;
    end else if (flt) begin
      if (!latch_mode) begin
        if (cnt < CW'(LO)) flt <= 1'b0;
        else               cnt <= cnt_dn;
      end
    end else if (rel_eff) begin
      cnt <= cnt_up;
      if (shut && cnt >= CW'(HI)) shut <= 1'b0;
    end
  end

  assign halt  = shut | ~sup_ok;
  assign fault = flt | shut;
endmodule

// File: rtl/ocp_shutdown_seq_chk.sv
`timescale 1ns/1ps
module ocp_shutdown_seq_chk #(
  parameter int FULL  = 1000,
  parameter int BLANK = 45
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       oc_hi,
  input logic                       oc_lo,
  input logic                       drv_hi,
  input logic                       drv_lo,
  input logic                       sup_a_ok,
  input logic                       sup_b_ok,
  input logic                       latch_mode,
  input logic                       halt,
  input logic                       fault,
  input logic                       req_s,
  input logic                       flt,
  input logic                       shut,
  input logic [$clog2(FULL+1)-1:0]  cnt
);
  localparam int LO = FULL * 3 / 10;
  localparam int HI = FULL * 7 / 10;
  localparam int CW = $clog2(FULL + 1);
  localparam int BW = $clog2(BLANK + 1);

  logic [BW-1:0] hon, lon;
  logic          trip, sup_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hon <= '0;
      lon <= '0;
    end else begin
      hon <= !drv_hi ? '0 : (hon == BW'(BLANK) ? hon : hon + 1'b1);
      lon <= !drv_lo ? '0 : (lon == BW'(BLANK) ? lon : lon + 1'b1);
    end
  end

  assign sup_ok = sup_a_ok && sup_b_ok;
  assign trip = (drv_hi && oc_hi && hon == BW'(BLANK)) ||
                (drv_lo && oc_lo && lon == BW'(BLANK));

  AST_OC_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!shut && sup_ok && !req_s && trip) |=> (halt && fault)); // R3
  AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!shut && sup_ok && !req_s && !trip) |=> !flt); // R4
  AST_SUPPLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_ok |=> (shut && cnt == '0)); // R7
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_mode && flt && sup_ok && !req_s) |=> flt); // R8
  AST_RELEASE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shut) |-> (cnt >= CW'(HI) && !flt)); // R5
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FULL)); // R2
  AST_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && sup_ok) |-> fault); // R11
  AST_LOW_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(flt) && sup_ok && !req_s) |-> cnt < CW'(LO)); // R5
endmodule

bind ocp_shutdown_seq ocp_shutdown_seq_chk #(.FULL(FULL), .BLANK(BLANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .oc_hi(oc_hi), .oc_lo(oc_lo),
  .drv_hi(drv_hi), .drv_lo(drv_lo), .sup_a_ok(sup_a_ok), .sup_b_ok(sup_b_ok),
  .latch_mode(latch_mode), .halt(halt), .fault(fault), .req_s(req_s),
  .flt(flt), .shut(shut), .cnt(cnt)
);

// File: tb/test_ocp_shutdown_seq.sv
`timescale 1ns/1ps
module test_ocp_shutdown_seq;
  localparam int FULL    = 20;
  localparam int BLANK   = 4;
  localparam int RST_MIN = 3;
  localparam int LO      = FULL * 3 / 10;
  localparam int HI      = FULL * 7 / 10;

  logic clk = 1'b0;
  logic rst_n, oc_hi, oc_lo, drv_hi, drv_lo, sup_a_ok, sup_b_ok, latch_mode, ext_req;
  logic halt, fault;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  ocp_shutdown_seq #(.FULL(FULL), .STEP_UP(1), .STEP_DN(1), .BLANK(BLANK), .RST_MIN(RST_MIN))
  i_ocp_shutdown_seq (
    .clk(clk), .rst_n(rst_n), .oc_hi(oc_hi), .oc_lo(oc_lo), .drv_hi(drv_hi),
    .drv_lo(drv_lo), .sup_a_ok(sup_a_ok), .sup_b_ok(sup_b_ok),
    .latch_mode(latch_mode), .ext_req(ext_req), .halt(halt), .fault(fault)
  );

  function automatic int shut_len(input int c);
    return c + HI - 2 * LO + 4;
  endfunction

  task automatic chk(input string what, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp_v);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_low(input int lim, output int n);
    n = lim + 1;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (!halt) begin
        n = i;
        return;
      end
    end
  endtask

  task automatic set_drv(input int side, input logic v);
    if (side == 0) drv_hi = v; else drv_lo = v;
  endtask

  task automatic set_oc(input int side, input logic v);
    if (side == 0) oc_hi = v; else oc_lo = v;
  endtask

  task automatic pulse_req(input int h);
    ext_req = 1'b1;
    tick(h);
    ext_req = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    rst_n = 0; oc_hi = 0; oc_lo = 0; drv_hi = 0; drv_lo = 0;
    sup_a_ok = 1; sup_b_ok = 1; latch_mode = 0; ext_req = 0;
    tick(3);
    chk("R1 halt in reset", halt, 1);
    chk("R1 fault in reset", fault, 1);
    rst_n = 1;
    count_low(100, n);
    chk("R2 power-up release", n, HI + 1);
    chk("R11 fault low when released", fault, 0);
    tick(FULL + 2);

    for (int side = 0; side < 2; side++) begin
      for (int k = 0; k < BLANK; k++) begin
        set_drv(side, 1); tick(k);
        set_oc(side, 1); tick(1);
        set_oc(side, 0); tick(2);
        chk($sformatf("R4 blanked flag side%0d offset%0d", side, k), halt, 0);
        set_drv(side, 0); tick(1);
      end
    end
    oc_hi = 1; oc_lo = 1; tick(6);
    chk("R4 flags with drives off", halt, 0);
    oc_hi = 0; oc_lo = 0; tick(1);

    for (int side = 0; side < 2; side++) begin
      set_drv(side, 1); tick(BLANK);
      set_oc(side, 1); tick(1);
      set_oc(side, 0); set_drv(side, 0);
      chk($sformatf("R3 trip side%0d", side), halt, 1);
      chk("R11 fault during shutdown", fault, 1);
      count_low(100, n);
      chk($sformatf("R5 self-reset length side%0d", side), n, shut_len(FULL));
      tick(FULL + 2);
    end

    drv_hi = 1; tick(BLANK);
    oc_hi = 1; tick(1);
    chk("R6 first trip", halt, 1);
    count_low(100, n);
    chk("R6 first shutdown length", n, shut_len(FULL));
    @(negedge clk);
    chk("R6 one run cycle then retrip", halt, 1);
    count_low(100, n);
    oc_hi = 0; drv_hi = 0;
    chk("R6 repeat shutdown length", n, shut_len(HI + 1));
    tick(4);
    chk("R6 stays running after flag clears", halt, 0);
    tick(FULL + 2);

    sup_a_ok = 0; #1;
    chk("R7 supply a loss immediate", halt, 1);
    tick(3); sup_a_ok = 1;
    count_low(100, n);
    chk("R7 restart after supply a", n, HI + 1);
    tick(FULL + 2);
    sup_b_ok = 0; #1;
    chk("R7 supply b loss immediate", halt, 1);
    tick(2); sup_b_ok = 1;
    count_low(100, n);
    chk("R7 restart after supply b", n, HI + 1);
    tick(FULL + 2);

    ext_req = 1; tick(1);
    ext_req = 0; tick(1);
    chk("R12 no effect before sync", halt, 0);
    tick(1);
    chk("R12 effect after two flops", halt, 1);
    count_low(100, n);
    chk("R10 release after short request", n, HI + 1);
    tick(FULL + 2);
    pulse_req(5);
    chk("R10 held request shuts down", halt, 1);
    count_low(100, n);
    chk("R10 release after request", n, HI + 3);
    tick(FULL + 2);

    latch_mode = 1; rst_n = 0; tick(2);
    rst_n = 1; tick(40);
    chk("R9 latched start-up holds", halt, 1);
    for (int h = 1; h < RST_MIN; h++) begin
      pulse_req(h);
      count_low(30, n);
      chk($sformatf("R9 short request %0d ignored", h), n, 31);
    end
    pulse_req(RST_MIN);
    count_low(100, n);
    chk("R9 qualifying request releases", n, HI + 3);
    tick(FULL + 2);
    drv_lo = 1; tick(BLANK);
    oc_lo = 1; tick(1);
    oc_lo = 0; drv_lo = 0;
    chk("R3 latched trip", halt, 1);
    tick(60);
    chk("R8 latched halt held", halt, 1);
    chk("R8 latched fault held", fault, 1);
    pulse_req(RST_MIN + 1);
    count_low(100, n);
    chk("R9 release after latched fault", n, HI + 3);
    chk("R11 fault low after latched release", fault, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule